// File: doc/BRIEF.md
# Commit-Protected GPIO Port Configuration

This block holds the configuration of an eight-pin general-purpose I/O port behind a simple word-addressed register bus (address, write data, write enable, combinational read data). For every pin it stores an output value, a direction bit, an alternate-function enable, a four-bit peripheral function select, pull-up and pull-down enables and a digital enable. From these it steers each pad either from the port's own data and direction bits or from one of sixteen peripheral sources. The pull and digital-enable bits go straight to the pad.

A parameter marks some pins as protected. By default these are pins 3..0, which carry the debug port. On a protected pin, bus writes to the alternate-function, pull-up, pull-down and digital-enable bits are dropped unless two conditions hold. The port must be unlocked by writing a 32-bit key word, and the pin's bit in the commit register must be set. The lock is a two-state machine with states ST_LOCKED and ST_UNLOCKED. Transition KEY_MATCH (a key-register write carrying the key) moves to ST_UNLOCKED. Transition KEY_MISS (a key-register write with any other value) moves to ST_LOCKED. Reset always enters ST_LOCKED.

After reset the protected pins come up already driving peripheral function 1, so a debugger can attach. A per-pin tamper enable input overrides everything else on its pin.

Top module: `gpio_cfg_guard`

## Requirements
- R1: The register map is a word index on `bus_addr`: 0 output data, 1 direction, 2 alternate-function enable, 3 function select, 4 pull-up, 5 pull-down, 6 digital enable, 7 key, 8 commit. After reset, unprotected pins read 0 in data, direction, alternate function, pulls, digital enable and their function-select nibble, and their `pad_oe` is 0.
- R2: Reset, including a later reset pulse, puts protected pins at alternate function 1, digital enable 1, pull-up 1, pull-down 0, function select 1 and commit 0. The key register reads 1 (locked) after reset.
- R3: With the alternate-function bit 0 and no tamper, `pad_out` equals the data bit and `pad_oe` equals direction AND digital enable.
- R4: With the alternate-function bit 1 and no tamper, the pin's source is peripheral f. Here f is the function-select nibble at bits 4p+3..4p, and the source is `periph_out[16p+f]`. `pad_oe` is `periph_oe[16p+f]` AND digital enable.
- R5: Writing 32'h5A17_C0DE to the key register unlocks the port, and writing any other value locks it. Reading the key register returns 0 when unlocked and 1 when locked.
- R6: On protected pins, writes to the alternate-function, pull-up, pull-down and digital-enable registers take effect only when the port is unlocked and the pin's commit bit is 1. The unprotected bits of the same write always take effect.
- R7: The commit register changes only on writes made while unlocked. Its bits for unprotected pins read 1.
- R8: The function select is writable on every pin at any time. The gate of R6 still holds for a protected pin set to a function other than 1.
- R9: With `tamper_en[p]` at 1, `pad_out[p]` equals `tamper_out[p]` and `pad_oe[p]` equals `tamper_oe[p]`, regardless of the alternate-function bit and the digital enable.
- R10: A write that sets a pull-up bit clears the same pin's pull-down bit, and a write that sets a pull-down bit clears the pull-up bit. Both are never 1 together.
- R11: Register indices 9 to 15 read 0 and writes to them change nothing. Bits above the pin count in 8-bit registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| periph_out | input | 128 | Peripheral output values, 16 per pin |
| periph_oe | input | 128 | Peripheral output enables, 16 per pin |
| tamper_en | input | 8 | Per-pin tamper override enable |
| tamper_out | input | 8 | Tamper output values |
| tamper_oe | input | 8 | Tamper output enables |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_pd | output | 8 | Pad pull-down enable |
| pad_den | output | 8 | Pad digital enable |

## Verification
Two functions can fall in the same cycle: the tamper override rising on a pin, and a committed bus write that clears that pin's alternate-function bit. The bench provokes this by raising `tamper_en` on the same clock edge as the write is presented. It judges the pad against the tamper inputs both before and after the write lands. Once tamper is released, the bench requires the pad to follow the port's data path, which proves the write was stored underneath the override.

// File: rtl/gpcfg_pkg.sv
package gpcfg_pkg;

    localparam int REG_IDX_W = 4;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_DATA   = 4'd0,
        IDX_DIR    = 4'd1,
        IDX_ALT    = 4'd2,
        IDX_FSEL   = 4'd3,
        IDX_PULLUP = 4'd4,
        IDX_PULLDN = 4'd5,
        IDX_DEN    = 4'd6,
        IDX_KEY    = 4'd7,
        IDX_COMMIT = 4'd8
    } reg_idx_e;

    typedef enum logic {
        ST_LOCKED   = 1'b0,
        ST_UNLOCKED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/gpcfg_lock_fsm.sv
module gpcfg_lock_fsm
    import gpcfg_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] UNLOCK_KEY = 32'h5A17_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_wdata,
    output logic              unlocked
);

    localparam logic [DATA_W-1:0] KEY_VAL = DATA_W'(UNLOCK_KEY);

    lock_state_e state_q, state_d;
    logic        key_match;

    assign key_match = (key_wdata == KEY_VAL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: KEY_MATCH and KEY_MISS transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (key_wr && key_match) begin
                    state_d = ST_UNLOCKED;
                end
            end
            ST_UNLOCKED: begin
                if (key_wr && !key_match) begin
                    state_d = ST_LOCKED;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_UNLOCKED: unlocked = 1'b1;
            default:     unlocked = 1'b0;
        endcase
    end

    AST_KEY_MISS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_match) |=> !unlocked); // R5

    AST_KEY_MATCH_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_match) |=> unlocked); // R5

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr) |=> (unlocked == $past(unlocked))); // R5

endmodule

// File: rtl/gpcfg_regs.sv
module gpcfg_regs
    import gpcfg_pkg::*;
#(
    parameter int NPINS      = 8,
    parameter int FSEL_W     = 4,
    parameter int DATA_W     = 32,
    parameter logic [NPINS-1:0] PROT_MASK = 8'h0F,
    parameter int DEBUG_FUNC = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_IDX_W-1:0]    addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    unlocked,
    output logic [DATA_W-1:0]       rdata,
    output logic [NPINS-1:0]        data_q,
    output logic [NPINS-1:0]        dir_q,
    output logic [NPINS-1:0]        alt_q,
    output logic [NPINS*FSEL_W-1:0] fsel_q,
    output logic [NPINS-1:0]        pu_q,
    output logic [NPINS-1:0]        pd_q,
    output logic [NPINS-1:0]        den_q
);

    localparam int FSEL_BITS = NPINS * FSEL_W;
    localparam logic [NPINS-1:0] PROT = PROT_MASK;

    function automatic logic [FSEL_BITS-1:0] fsel_reset_val();
        logic [FSEL_BITS-1:0] v;
        v = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (PROT[p]) begin
                v[p*FSEL_W +: FSEL_W] = FSEL_W'(DEBUG_FUNC);
            end
        end
        return v;
    endfunction

    localparam logic [FSEL_BITS-1:0] FSEL_RST = fsel_reset_val();

    reg_idx_e         idx;
    logic [NPINS-1:0] cr_q;
    logic [NPINS-1:0] wd_pin;
    logic [NPINS-1:0] wmask;
    logic [NPINS-1:0] set_bits;

    assign idx      = reg_idx_e'(addr);
    assign wd_pin   = wdata[NPINS-1:0];
    // unprotected bits always pass; protected ones need unlock and commit
    assign wmask    = ~PROT | (cr_q & PROT & {NPINS{unlocked}});
    assign set_bits = wd_pin & wmask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            alt_q  <= PROT;
            fsel_q <= FSEL_RST;
            pu_q   <= PROT;
            pd_q   <= '0;
            den_q  <= PROT;
            cr_q   <= '0;
        end else if (wr_en) begin
            unique case (idx)
                IDX_DATA:   data_q <= wd_pin;
                IDX_DIR:    dir_q  <= wd_pin;
                IDX_ALT:    alt_q  <= (alt_q & ~wmask) | set_bits;
                IDX_FSEL:   fsel_q <= wdata[FSEL_BITS-1:0];
                IDX_PULLUP: begin
                    pu_q <= (pu_q & ~wmask) | set_bits;
                    pd_q <= pd_q & ~set_bits;
                end
                IDX_PULLDN: begin
                    pd_q <= (pd_q & ~wmask) | set_bits;
                    pu_q <= pu_q & ~set_bits;
                end
                IDX_DEN:    den_q  <= (den_q & ~wmask) | set_bits;
                IDX_COMMIT: begin
                    if (unlocked) begin
                        cr_q <= wd_pin & PROT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (idx)
            IDX_DATA:   rdata[NPINS-1:0]     = data_q;
            IDX_DIR:    rdata[NPINS-1:0]     = dir_q;
            IDX_ALT:    rdata[NPINS-1:0]     = alt_q;
            IDX_FSEL:   rdata[FSEL_BITS-1:0] = fsel_q;
            IDX_PULLUP: rdata[NPINS-1:0]     = pu_q;
            IDX_PULLDN: rdata[NPINS-1:0]     = pd_q;
            IDX_DEN:    rdata[NPINS-1:0]     = den_q;
            IDX_KEY:    rdata[0]             = ~unlocked;
            IDX_COMMIT: rdata[NPINS-1:0]     = cr_q | ~PROT;
            default:    rdata                = '0;
        endcase
    end

    AST_PROT_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable({alt_q & PROT, pu_q & PROT, pd_q & PROT, den_q & PROT})); // R6

    AST_COMMIT_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(cr_q)); // R7

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_q & pd_q) == '0); // R10

    AST_UNUSED_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > REG_IDX_W'(IDX_COMMIT)) |=>
        $stable({data_q, dir_q, alt_q, fsel_q, pu_q, pd_q, den_q, cr_q})); // R11

endmodule

// File: rtl/gpcfg_pin_mux.sv
module gpcfg_pin_mux #(
    parameter int FSEL_W = 4,
    parameter int NFUNC  = 1 << FSEL_W
) (
    input  logic              alt,
    input  logic              den,
    input  logic              gpio_out,
    input  logic              gpio_dir,
    input  logic [FSEL_W-1:0] fsel,
    input  logic [NFUNC-1:0]  src_out,
    input  logic [NFUNC-1:0]  src_oe,
    input  logic              tmp_en,
    input  logic              tmp_out,
    input  logic              tmp_oe,
    output logic              pad_out,
    output logic              pad_oe
);

    logic sel_out;
    logic sel_oe;

    always_comb begin
        if (alt) begin
            sel_out = src_out[fsel];
            sel_oe  = src_oe[fsel];
        end else begin
            sel_out = gpio_out;
            sel_oe  = gpio_dir;
        end
        if (tmp_en) begin
            pad_out = tmp_out;
            pad_oe  = tmp_oe;
        end else begin
            pad_out = sel_out;
            pad_oe  = sel_oe & den;
        end
    end

endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
    import gpcfg_pkg::*;
#(
    parameter int          NPINS      = 8,
    parameter int          FSEL_W     = 4,
    parameter int          DATA_W     = 32,
    parameter logic [7:0]  PROT_MASK  = 8'h0F,
    parameter int          DEBUG_FUNC = 1,
    parameter logic [31:0] UNLOCK_KEY = 32'h5A17_C0DE,
    localparam int         NFUNC      = 1 << FSEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REG_IDX_W-1:0]   bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NPINS*NFUNC-1:0] periph_out,
    input  logic [NPINS*NFUNC-1:0] periph_oe,
    input  logic [NPINS-1:0]       tamper_en,
    input  logic [NPINS-1:0]       tamper_out,
    input  logic [NPINS-1:0]       tamper_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pad_pu,
    output logic [NPINS-1:0]       pad_pd,
    output logic [NPINS-1:0]       pad_den
);

    logic                    unlocked;
    logic                    key_wr;
    logic [NPINS-1:0]        data_q;
    logic [NPINS-1:0]        dir_q;
    logic [NPINS-1:0]        alt_q;
    logic [NPINS*FSEL_W-1:0] fsel_q;

    assign key_wr = bus_we && (bus_addr == REG_IDX_W'(IDX_KEY));

    gpcfg_lock_fsm #(
        .DATA_W     (DATA_W),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_wdata (bus_wdata),
        .unlocked  (unlocked)
    );

    gpcfg_regs #(
        .NPINS      (NPINS),
        .FSEL_W     (FSEL_W),
        .DATA_W     (DATA_W),
        .PROT_MASK  (PROT_MASK[NPINS-1:0]),
        .DEBUG_FUNC (DEBUG_FUNC)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .rdata    (bus_rdata),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .alt_q    (alt_q),
        .fsel_q   (fsel_q),
        .pu_q     (pad_pu),
        .pd_q     (pad_pd),
        .den_q    (pad_den)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpcfg_pin_mux #(
            .FSEL_W (FSEL_W),
            .NFUNC  (NFUNC)
        ) u_mux (
            .alt      (alt_q[p]),
            .den      (pad_den[p]),
            .gpio_out (data_q[p]),
            .gpio_dir (dir_q[p]),
            .fsel     (fsel_q[p*FSEL_W +: FSEL_W]),
            .src_out  (periph_out[p*NFUNC +: NFUNC]),
            .src_oe   (periph_oe[p*NFUNC +: NFUNC]),
            .tmp_en   (tamper_en[p]),
            .tmp_out  (tamper_out[p]),
            .tmp_oe   (tamper_oe[p]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p])
        );
    end

    AST_TAMPER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & tamper_en) == (tamper_out & tamper_en)) &&
        ((pad_oe & tamper_en) == (tamper_oe & tamper_en))); // R9

    AST_NO_DRIVE_WITHOUT_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~tamper_en & ~pad_den) == '0); // R3

endmodule

// File: tb/gpio_cfg_guard_tb_top.sv
module gpio_cfg_guard_tb_top;

    localparam logic [31:0] KEY = 32'h5A17_C0DE;
    localparam logic [127:0] P_OUT = 128'h9F3C_62A1_0E57_D4B8_7C19_E6A3_3B50_C8D2;
    localparam logic [127:0] P_OE  = 128'h36E1_A94C_D208_5F7B_C3A6_185D_E0F4_2B97;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] periph_out = P_OUT;
    logic [127:0] periph_oe  = P_OE;
    logic [7:0]   tamper_en = '0;
    logic [7:0]   tamper_out = '0;
    logic [7:0]   tamper_oe = '0;
    logic [7:0]   pad_out, pad_oe, pad_pu, pad_pd, pad_den;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    gpio_cfg_guard dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_out(periph_out), .periph_oe(periph_oe),
        .tamper_en(tamper_en), .tamper_out(tamper_out), .tamper_oe(tamper_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_den(pad_den)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset_state();
        rd_check("R1 data reset", 4'd0, 32'h0);
        rd_check("R1 dir reset", 4'd1, 32'h0);
        rd_check("R2 alt reset", 4'd2, 32'h0F);
        rd_check("R2 fsel reset", 4'd3, 32'h0000_1111);
        rd_check("R2 pullup reset", 4'd4, 32'h0F);
        rd_check("R2 pulldown reset", 4'd5, 32'h00);
        rd_check("R2 den reset", 4'd6, 32'h0F);
        rd_check("R2 key locked", 4'd7, 32'h1);
        rd_check("R7 commit reset", 4'd8, 32'hF0);
        check("R1 pad_oe high pins", {28'h0, pad_oe[7:4]}, 32'h0);
        for (int p = 0; p < 4; p++) begin
            check("R4 debug pin out", {31'h0, pad_out[p]}, {31'h0, P_OUT[p*16+1]});
            check("R4 debug pin oe", {31'h0, pad_oe[p]}, {31'h0, P_OE[p*16+1]});
        end
    endtask

    task automatic t_locked_write();
        wr(4'd2, 32'h00);
        rd_check("R6 alt locked clear", 4'd2, 32'h0F);
        wr(4'd2, 32'hF0);
        rd_check("R6 alt unprotected set", 4'd2, 32'hFF);
        wr(4'd4, 32'h00);
        rd_check("R6 pullup locked", 4'd4, 32'h0F);
    endtask

    task automatic t_gpio_path();
        wr(4'd2, 32'h00);
        rd_check("R6 alt unprotected clear", 4'd2, 32'h0F);
        wr(4'd0, 32'hA0);
        wr(4'd1, 32'hF0);
        wr(4'd6, 32'hF0);
        rd_check("R6 den mixed", 4'd6, 32'hFF);
        check("R3 gpio pad_out", {28'h0, pad_out[7:4]}, 32'hA);
        check("R3 gpio pad_oe", {28'h0, pad_oe[7:4]}, 32'hF);
        wr(4'd6, 32'h00);
        check("R3 den gates oe", {28'h0, pad_oe[7:4]}, 32'h0);
    endtask

    task automatic t_periph_path();
        wr(4'd3, 32'h00A5_1111);
        wr(4'd2, 32'h30);
        rd_check("R4 alt set", 4'd2, 32'h3F);
        wr(4'd6, 32'h30);
        check("R4 pin4 func5 out", {31'h0, pad_out[4]}, {31'h0, P_OUT[4*16+5]});
        check("R4 pin4 func5 oe", {31'h0, pad_oe[4]}, {31'h0, P_OE[4*16+5]});
        check("R4 pin5 funcA out", {31'h0, pad_out[5]}, {31'h0, P_OUT[5*16+10]});
        check("R4 pin5 funcA oe", {31'h0, pad_oe[5]}, {31'h0, P_OE[5*16+10]});
    endtask

    task automatic t_lock_commit();
        wr(4'd8, 32'h0F);
        rd_check("R7 commit locked write", 4'd8, 32'hF0);
        wr(4'd7, KEY);
        rd_check("R5 key unlocked", 4'd7, 32'h0);
        wr(4'd8, 32'h05);
        rd_check("R7 commit unlocked write", 4'd8, 32'hF5);
        wr(4'd2, 32'h30);
        rd_check("R6 alt committed pins only", 4'd2, 32'h3A);
        wr(4'd7, 32'h0);
        rd_check("R5 wrong key relocks", 4'd7, 32'h1);
        wr(4'd2, 32'h3F);
        rd_check("R6 alt after relock", 4'd2, 32'h3A);
    endtask

    task automatic t_other_func();
        wr(4'd3, 32'h00A5_1117);
        rd_check("R8 fsel write locked", 4'd3, 32'h00A5_1117);
        wr(4'd2, 32'h3F);
        rd_check("R8 gate with func7", 4'd2, 32'h3A);
        check("R3 pin0 gpio dir0", {31'h0, pad_oe[0]}, 32'h0);
        wr(4'd7, KEY);
        wr(4'd2, 32'h3F);
        rd_check("R8 alt committed func7", 4'd2, 32'h3F);
        check("R8 pin0 func7 out", {31'h0, pad_out[0]}, {31'h0, P_OUT[7]});
        check("R8 pin0 func7 oe", {31'h0, pad_oe[0]}, {31'h0, P_OE[7]});
    endtask

    task automatic t_pull();
        wr(4'd5, 32'h11);
        rd_check("R10 pd set", 4'd5, 32'h11);
        rd_check("R10 pu cleared", 4'd4, 32'h0E);
        check("R10 pad_pu", {24'h0, pad_pu}, 32'h0E);
        wr(4'd4, 32'h10);
        rd_check("R10 pu set", 4'd4, 32'h1A);
        check("R10 pad_pd", {24'h0, pad_pd}, 32'h01);
    endtask

    task automatic t_tamper_race();
        @(negedge clk);
        tamper_en  = 8'hA0;
        tamper_out = 8'h80;
        tamper_oe  = 8'hA0;
        bus_addr   = 4'd2;
        bus_wdata  = 32'h1F;
        bus_we     = 1'b1;
        #1;
        check("R9 pin5 tamper before write", {30'h0, pad_out[5], pad_oe[5]}, 32'h1);
        check("R9 pin7 tamper no den", {30'h0, pad_out[7], pad_oe[7]}, 32'h3);
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        check("R9 pin5 tamper after write", {30'h0, pad_out[5], pad_oe[5]}, 32'h1);
        rd_check("R6 alt stored under tamper", 4'd2, 32'h1F);
        tamper_en = 8'h00;
        #1;
        check("R3 pin5 gpio after release", {30'h0, pad_out[5], pad_oe[5]}, 32'h3);
        check("R3 pin7 den0 after release", {31'h0, pad_oe[7]}, 32'h0);
    endtask

    task automatic t_reserved();
        wr(4'd0, 32'hFFFF_FFFF);
        rd_check("R11 data upper bits", 4'd0, 32'h0000_00FF);
        rd_check("R11 idx9 reads 0", 4'd9, 32'h0);
        wr(4'd12, 32'hFFFF_FFFF);
        rd_check("R11 idx12 reads 0", 4'd12, 32'h0);
        rd_check("R11 alt untouched", 4'd2, 32'h1F);
        rd_check("R11 idx15 reads 0", 4'd15, 32'h0);
    endtask

    task automatic t_por();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R2 por alt", 4'd2, 32'h0F);
        rd_check("R2 por fsel", 4'd3, 32'h0000_1111);
        rd_check("R2 por pullup", 4'd4, 32'h0F);
        rd_check("R2 por pulldown", 4'd5, 32'h0);
        rd_check("R2 por den", 4'd6, 32'h0F);
        rd_check("R2 por key", 4'd7, 32'h1);
        rd_check("R2 por commit", 4'd8, 32'hF0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_locked_write();
        t_gpio_path();
        t_periph_path();
        t_lock_commit();
        t_other_func();
        t_pull();
        t_tamper_race();
        t_reserved();
        t_por();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule